// File: doc/BRIEF.md
# Region-Based Data Access Guard

This block judges every data load and store on an internal bus against four programmable address regions and returns a pass or fault verdict in the same cycle as the request. Each region holds a base address, a compare mask (a power-of-two size is expressed as a run of ones from the top), and four attribute bits: enable, supervisor-only, guarded (no speculative loads) and read-only. An address that no enabled region covers falls back to a default entry that carries its own supervisor-only and guarded bits. A single checking-enable input turns all checking off. One fixed calibration-memory window, set by parameters, is never checked.

When an access faults, the first fault is captured with its cause and address. The capture holds, and the interrupt stays high, until software writes the cause register. Software programs the regions through a simple register port that has a write strobe, an index, write data and combinational read data.

Top module: `dprot_unit`

## Requirements
- R1: After a synchronous reset every configuration register reads 0, so all regions are disabled and the default entry allows user access with no guard. No fault is recorded and `irq` is low.
- R2: Region i matches only when its enable bit (attribute bit 0) is 1 and `((acc_addr ^ base_i) & mask_i) == 0`. A disabled region never matches.
- R3: When several enabled regions match, the one with the lowest index decides the attributes.
- R4: A user access (`acc_super`=0) to space whose supervisor-only bit (attribute bit 1) is set faults with cause 1. A supervisor access is allowed there.
- R5: A write to space whose read-only bit (attribute bit 3) is set faults with cause 3. Reads there pass.
- R6: A load from space whose guarded bit (attribute bit 2) is set faults with cause 2. Writes there pass.
- R7: When several rules break at once, cause 1 takes precedence over cause 3, and cause 3 over cause 2.
- R8: An address matched by no enabled region is judged with the default entry (register index 12, bit 1 supervisor-only, bit 2 guarded). Its other bits are forced to 0 and read back as 0.
- R9: With `chk_en` low, every access passes.
- R10: An address with `((acc_addr ^ EXEMPT_BASE) & EXEMPT_MASK) == 0` never faults. The default window is 0x0038_0000 with mask 0xFFFF_8000.
- R11: `acc_fault` and `acc_cause` are combinational from the current request. With `acc_valid` low they are 0.
- R12: A faulting access is recorded at the next clock edge (`flt_cause`, `flt_addr`) only if no fault is already held. A held fault keeps both values and keeps `irq` high until any write to index 13. That write clears the record to 0, except that a fault in the same cycle is recorded instead.
- R13: Register indices: 0-3 region base, 4-7 region mask, 8-11 region attributes (bits 3:0), 12 default entry, 13 fault cause (read, or write to clear), 14 fault address (read only). Unused indices read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Data access request present |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_super | input | 1 | 1 = supervisor privilege, 0 = user |
| chk_en | input | 1 | Global checking enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register index |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Register read data (combinational) |
| acc_fault | output | 1 | Current access violates a rule |
| acc_cause | output | 2 | Cause of the current access (0 none, 1 privilege, 2 guarded load, 3 read-only write) |
| irq | output | 1 | Fault interrupt, high while a fault is recorded |
| flt_cause | output | 2 | Recorded fault cause |
| flt_addr | output | ADDR_W | Recorded fault address |

## Verification
Accesses are tried in several forms. User and supervisor loads and stores go to addresses that hit one region, two overlapping regions, only the default entry, and a spot just outside a region's mask. These tell apart a wrong match, a wrong priority between regions, and a wrong fallback to the default entry. Loads against stores to a region with several attributes set separate the read-only, guarded and privilege rules and their precedence. Requests aimed at the exempt window and its edge, requests with checking disabled, and idle cycles carrying a violating address isolate the three bypasses. Back-to-back faults, and a clear that lands together with a new fault, exercise the record-and-hold path.

// File: rtl/dprot_pkg.sv
package dprot_pkg;

    // Region attribute word, bit 0 .. bit 3
    typedef struct packed {
        logic ro;    // bit 3: stores forbidden
        logic grd;   // bit 2: loads forbidden (non-speculative space)
        logic sup;   // bit 1: supervisor only
        logic en;    // bit 0: region active
    } rgn_attr_t;

    localparam int ATTR_W = $bits(rgn_attr_t);

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_PRIV = 2'd1,
        CAUSE_GRD  = 2'd2,
        CAUSE_RO   = 2'd3
    } cause_t;

    // Rule evaluation in precedence order: privilege, read-only, guarded
    function automatic cause_t rule_eval(rgn_attr_t a, logic is_super, logic is_write);
        if (a.sup && !is_super) return CAUSE_PRIV;
        if (a.ro  &&  is_write) return CAUSE_RO;
        if (a.grd && !is_write) return CAUSE_GRD;
        return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/dprot_regs.sv
module dprot_regs
    import dprot_pkg::*;
#(
    parameter int NUM_RGN = 4,
    parameter int ADDR_W  = 32,
    parameter int CFG_AW  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] rgn_base [NUM_RGN],
    output logic [ADDR_W-1:0] rgn_mask [NUM_RGN],
    output rgn_attr_t         rgn_attr [NUM_RGN],
    output rgn_attr_t         dflt_attr
);
    localparam int MASK_OFS = NUM_RGN;
    localparam int ATTR_OFS = 2 * NUM_RGN;
    localparam int DFLT_IDX = 3 * NUM_RGN;

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        always_ff @(posedge clk) begin
            if (rst) begin
                rgn_base[g] <= '0;
                rgn_mask[g] <= '0;
                rgn_attr[g] <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == CFG_AW'(g))
                    rgn_base[g] <= cfg_wdata;
                if (cfg_addr == CFG_AW'(MASK_OFS + g))
                    rgn_mask[g] <= cfg_wdata;
                if (cfg_addr == CFG_AW'(ATTR_OFS + g))
                    rgn_attr[g] <= rgn_attr_t'(cfg_wdata[ATTR_W-1:0]);
            end
        end
    end

    // Default entry keeps only its privilege and guard bits
    always_ff @(posedge clk) begin
        if (rst)
            dflt_attr <= '0;
        else if (cfg_we && cfg_addr == CFG_AW'(DFLT_IDX))
            dflt_attr <= '{ro: 1'b0, grd: cfg_wdata[2], sup: cfg_wdata[1], en: 1'b0};
    end

endmodule

// File: rtl/dprot_match.sv
module dprot_match
    import dprot_pkg::*;
#(
    parameter int NUM_RGN = 4,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] rgn_base [NUM_RGN],
    input  logic [ADDR_W-1:0] rgn_mask [NUM_RGN],
    input  rgn_attr_t         rgn_attr [NUM_RGN],
    output logic              any_hit,
    output logic [IDX_W-1:0]  win_idx,
    output rgn_attr_t         win_attr
);
    logic [NUM_RGN-1:0] hit_vec;

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_cmp
        assign hit_vec[g] = rgn_attr[g].en &&
                            (((addr ^ rgn_base[g]) & rgn_mask[g]) == '0);
    end

    // Scan from the top so the lowest index is left standing
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = NUM_RGN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
        win_attr = rgn_attr[win_idx];
    end

endmodule

// File: rtl/dprot_check.sv
module dprot_check
    import dprot_pkg::*;
(
    input  logic      acc_valid,
    input  logic      chk_en,
    input  logic      in_exempt,
    input  logic      any_hit,
    input  rgn_attr_t win_attr,
    input  rgn_attr_t dflt_attr,
    input  logic      is_super,
    input  logic      is_write,
    output logic      fault,
    output cause_t    cause
);
    rgn_attr_t eff;

    always_comb begin
        eff   = any_hit ? win_attr : dflt_attr;
        cause = CAUSE_NONE;
        if (acc_valid && chk_en && !in_exempt && (!any_hit || eff.en))
            cause = rule_eval(eff, is_super, is_write);
        fault = (cause != CAUSE_NONE);
    end

endmodule

// File: rtl/dprot_log.sv
module dprot_log
    import dprot_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              fault,
    input  cause_t            cause,
    input  logic [ADDR_W-1:0] addr,
    output cause_t            flt_cause,
    output logic [ADDR_W-1:0] flt_addr,
    output logic              irq
);
    cause_t            nxt_cause;
    logic [ADDR_W-1:0] nxt_addr;
    logic              room;

    always_comb begin
        room      = clr || (flt_cause == CAUSE_NONE);
        nxt_cause = flt_cause;
        nxt_addr  = flt_addr;
        if (clr) begin
            nxt_cause = CAUSE_NONE;
            nxt_addr  = '0;
        end
        if (room && fault) begin
            nxt_cause = cause;
            nxt_addr  = addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_cause <= CAUSE_NONE;
            flt_addr  <= '0;
            irq       <= 1'b0;
        end else begin
            flt_cause <= nxt_cause;
            flt_addr  <= nxt_addr;
            irq       <= fault || ((flt_cause != CAUSE_NONE) && !clr);
        end
    end

    // R12: a held record does not move until cleared
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        (flt_cause != CAUSE_NONE && !clr) |=> ($stable(flt_cause) && $stable(flt_addr)));

    // R12: a fault with room is captured at the next edge
    a_r12_capture: assert property (@(posedge clk) disable iff (rst)
        (fault && (clr || flt_cause == CAUSE_NONE)) |=>
            (flt_cause == $past(cause) && flt_addr == $past(addr)));

    // R12: clear without a new fault empties the record
    a_r12_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !fault) |=> (flt_cause == CAUSE_NONE));

    // R12: interrupt follows the record
    a_r12_irq: assert property (@(posedge clk) disable iff (rst)
        irq == (flt_cause != CAUSE_NONE));

endmodule

// File: rtl/dprot_unit.sv
module dprot_unit
    import dprot_pkg::*;
#(
    parameter int              NUM_RGN     = 4,
    parameter int              ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] EXEMPT_BASE = 32'h0038_0000,
    parameter logic [ADDR_W-1:0] EXEMPT_MASK = 32'hFFFF_8000,
    localparam int             CFG_AW      = $clog2(3 * NUM_RGN + 3)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_super,
    input  logic              chk_en,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              acc_fault,
    output logic [1:0]        acc_cause,
    output logic              irq,
    output logic [1:0]        flt_cause,
    output logic [ADDR_W-1:0] flt_addr
);
    localparam int IDX_W    = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1;
    localparam int DFLT_IDX = 3 * NUM_RGN;
    localparam int FC_IDX   = DFLT_IDX + 1;
    localparam int FA_IDX   = DFLT_IDX + 2;

    logic [ADDR_W-1:0] rgn_base [NUM_RGN];
    logic [ADDR_W-1:0] rgn_mask [NUM_RGN];
    rgn_attr_t         rgn_attr [NUM_RGN];
    rgn_attr_t         dflt_attr;
    logic              any_hit;
    logic [IDX_W-1:0]  win_idx;
    rgn_attr_t         win_attr;
    logic              in_exempt;
    cause_t            chk_cause;
    cause_t            log_cause;
    logic              clr;

    dprot_regs #(.NUM_RGN(NUM_RGN), .ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rgn_base(rgn_base), .rgn_mask(rgn_mask), .rgn_attr(rgn_attr), .dflt_attr(dflt_attr)
    );

    dprot_match #(.NUM_RGN(NUM_RGN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
        .addr(acc_addr), .rgn_base(rgn_base), .rgn_mask(rgn_mask), .rgn_attr(rgn_attr),
        .any_hit(any_hit), .win_idx(win_idx), .win_attr(win_attr)
    );

    assign in_exempt = (((acc_addr ^ EXEMPT_BASE) & EXEMPT_MASK) == '0);

    dprot_check u_check (
        .acc_valid(acc_valid), .chk_en(chk_en), .in_exempt(in_exempt), .any_hit(any_hit),
        .win_attr(win_attr), .dflt_attr(dflt_attr), .is_super(acc_super), .is_write(acc_write),
        .fault(acc_fault), .cause(chk_cause)
    );

    assign acc_cause = chk_cause;
    assign clr       = cfg_we && (cfg_addr == CFG_AW'(FC_IDX));

    dprot_log #(.ADDR_W(ADDR_W)) u_log (
        .clk(clk), .rst(rst), .clr(clr), .fault(acc_fault), .cause(chk_cause), .addr(acc_addr),
        .flt_cause(log_cause), .flt_addr(flt_addr), .irq(irq)
    );

    assign flt_cause = log_cause;

    // Register read mux
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_RGN; i++) begin
            if (cfg_addr == CFG_AW'(i))               cfg_rdata = rgn_base[i];
            if (cfg_addr == CFG_AW'(NUM_RGN + i))     cfg_rdata = rgn_mask[i];
            if (cfg_addr == CFG_AW'(2 * NUM_RGN + i)) cfg_rdata = ADDR_W'(rgn_attr[i]);
        end
        if (cfg_addr == CFG_AW'(DFLT_IDX)) cfg_rdata = ADDR_W'(dflt_attr);
        if (cfg_addr == CFG_AW'(FC_IDX))   cfg_rdata = ADDR_W'(log_cause);
        if (cfg_addr == CFG_AW'(FA_IDX))   cfg_rdata = flt_addr;
    end

    // R9: checking disabled means no fault
    a_r9_off_pass: assert property (@(posedge clk) disable iff (rst)
        !chk_en |-> !acc_fault);

    // R10: exempt window never faults
    a_r10_exempt: assert property (@(posedge clk) disable iff (rst)
        in_exempt |-> !acc_fault);

    // R11: idle cycles never fault
    a_r11_idle: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !acc_fault);

    // R2: a winning region is always an enabled one
    a_r2_win_enabled: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> rgn_attr[win_idx].en);

    // R7: privilege mismatch beats every other cause
    a_r7_priv_first: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && chk_en && !in_exempt && any_hit && win_attr.sup && !acc_super)
            |-> (acc_cause == 2'd1));

endmodule

// File: tb/sim_dprot_unit.sv
module sim_dprot_unit;
    localparam int CLK_P = 10;
    localparam int NR    = 4;
    localparam int IX_DF = 12;
    localparam int IX_FC = 13;
    localparam int IX_FA = 14;
    localparam logic [31:0] EXB = 32'h0038_0000;
    localparam logic [31:0] EXM = 32'hFFFF_8000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr  = '0;
    logic        acc_write = 1'b0;
    logic        acc_super = 1'b0;
    logic        chk_en    = 1'b1;
    logic        cfg_we    = 1'b0;
    logic [3:0]  cfg_addr  = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_fault;
    logic [1:0]  acc_cause;
    logic        irq;
    logic [1:0]  flt_cause;
    logic [31:0] flt_addr;

    always #(CLK_P / 2) clk = ~clk;

    dprot_unit u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_super(acc_super), .chk_en(chk_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_fault(acc_fault), .acc_cause(acc_cause), .irq(irq),
        .flt_cause(flt_cause), .flt_addr(flt_addr)
    );

    // Behavioural reference state
    logic [31:0] m_base [NR];
    logic [31:0] m_mask [NR];
    logic [3:0]  m_attr [NR];
    logic [3:0]  m_dflt;
    int          m_fc;
    logic [31:0] m_fa;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string tag   = "R1";

    function automatic int ref_cause(logic v, logic en, logic [31:0] a, logic wr, logic sp);
        logic [3:0] at;
        bit found;
        if (!v || !en) return 0;
        if (((a ^ EXB) & EXM) == 0) return 0;
        at = m_dflt;
        found = 0;
        for (int i = 0; i < NR; i++) begin
            if (!found && m_attr[i][0] && (((a ^ m_base[i]) & m_mask[i]) == 0)) begin
                at = m_attr[i];
                found = 1;
            end
        end
        if (at[1] && !sp) return 1;
        if (at[3] && wr)  return 3;
        if (at[2] && !wr) return 2;
        return 0;
    endfunction

    task automatic check(string t, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", t, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int c;
        if (rst) begin
            for (int i = 0; i < NR; i++) begin
                m_base[i] = '0; m_mask[i] = '0; m_attr[i] = '0;
            end
            m_dflt = '0; m_fc = 0; m_fa = '0;
        end else begin
            c = ref_cause(acc_valid, chk_en, acc_addr, acc_write, acc_super);
            if (cfg_we && cfg_addr == IX_FC) begin
                m_fc = 0; m_fa = '0;
            end
            if (c != 0 && m_fc == 0) begin
                m_fc = c; m_fa = acc_addr;
            end
            if (cfg_we) begin
                if (cfg_addr < 4)                         m_base[cfg_addr] = cfg_wdata;
                else if (cfg_addr < 8)                    m_mask[cfg_addr-4] = cfg_wdata;
                else if (cfg_addr < 12)                   m_attr[cfg_addr-8] = cfg_wdata[3:0];
                else if (cfg_addr == IX_DF)               m_dflt = cfg_wdata[3:0] & 4'b0110;
            end
        end
    end

    // Per-cycle comparison against the model (R11 verdict, R12 record)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check({tag, " verdict R11"}, {30'b0, acc_cause},
                  ref_cause(acc_valid, chk_en, acc_addr, acc_write, acc_super));
            check({tag, " fault R11"}, {31'b0, acc_fault},
                  (ref_cause(acc_valid, chk_en, acc_addr, acc_write, acc_super) != 0) ? 1 : 0);
            check({tag, " cause R12"}, {30'b0, flt_cause}, m_fc);
            check({tag, " addr R12"}, flt_addr, m_fa);
            check({tag, " irq R12"}, {31'b0, irq}, (m_fc != 0) ? 1 : 0);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wcfg(int idx, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = 4'(idx); cfg_wdata = d; acc_valid = 1'b0;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic rcfg(int idx, logic [31:0] exp, string t);
        tag = t;
        cfg_addr = 4'(idx);
        #1;
        check({t, " readback"}, cfg_rdata, exp);
        tick();
    endtask

    task automatic acc(logic [31:0] a, logic w, logic s, int exp, string t);
        tag = t;
        acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_super = s;
        #1;
        check({t, " cause"}, {30'b0, acc_cause}, exp);
        tick();
        acc_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog all act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        for (int i = 0; i < 16; i++) rcfg(i, 32'h0, "R1");
        check("R1 irq", {31'b0, irq}, 0);

        // R8: default entry, permissive then supervisor-only
        acc(32'h4000_0000, 1'b0, 1'b0, 0, "R8");
        wcfg(IX_DF, 32'h2);
        acc(32'h4000_0000, 1'b0, 1'b0, 1, "R8");
        check("R12 captured cause", {30'b0, flt_cause}, 1);
        check("R12 captured addr", flt_addr, 32'h4000_0000);
        check("R12 irq high", {31'b0, irq}, 1);
        acc(32'h5000_0000, 1'b1, 1'b0, 1, "R8");
        check("R12 held addr", flt_addr, 32'h4000_0000);
        acc(32'h4000_0000, 1'b0, 1'b1, 0, "R4");
        tag = "R12";
        wcfg(IX_FC, 32'h0);
        check("R12 cleared", {30'b0, flt_cause}, 0);
        check("R12 irq low", {31'b0, irq}, 0);

        // R10: exempt window and its edge
        wcfg(IX_DF, 32'h6);
        acc(32'h0038_0100, 1'b0, 1'b0, 0, "R10");
        acc(32'h0038_8000, 1'b0, 1'b0, 1, "R10");
        wcfg(IX_FC, 32'h0);

        // R9: checking off
        chk_en = 1'b0;
        acc(32'h4000_0000, 1'b0, 1'b0, 0, "R9");
        chk_en = 1'b1;

        // R11: idle with a violating address
        tag = "R11";
        acc_valid = 1'b0; acc_addr = 32'h4000_0000; acc_write = 1'b0; acc_super = 1'b0;
        #1 check("R11 idle", {30'b0, acc_cause}, 0);
        tick();

        // R13 / R8: layout and default masking
        wcfg(IX_DF, 32'hF);
        rcfg(IX_DF, 32'h6, "R13");
        wcfg(IX_DF, 32'h0);
        wcfg(0, 32'h1000_0000);
        wcfg(4, 32'hFFFF_0000);
        wcfg(8, 32'h9);
        rcfg(0, 32'h1000_0000, "R13");
        rcfg(4, 32'hFFFF_0000, "R13");
        rcfg(8, 32'h9, "R13");

        // R5: read-only region
        acc(32'h1000_0010, 1'b1, 1'b1, 3, "R5");
        acc(32'h1000_0010, 1'b0, 1'b0, 0, "R5");
        rcfg(IX_FC, 32'h3, "R13");
        rcfg(IX_FA, 32'h1000_0010, "R13");
        wcfg(IX_FC, 32'h0);

        // R3 / R6: overlapping guarded region
        wcfg(1, 32'h1000_0000);
        wcfg(5, 32'hFF00_0000);
        wcfg(9, 32'h5);
        acc(32'h1000_0010, 1'b0, 1'b0, 0, "R3");
        acc(32'h1080_0000, 1'b0, 1'b1, 2, "R6");
        acc(32'h1080_0000, 1'b1, 1'b0, 0, "R6");
        wcfg(IX_FC, 32'h0);

        // R7 / R4: supervisor-only read-only region
        wcfg(2, 32'h2000_0000);
        wcfg(6, 32'hFFFF_F000);
        wcfg(10, 32'hB);
        acc(32'h2000_0004, 1'b1, 1'b0, 1, "R7");
        acc(32'h2000_0004, 1'b1, 1'b1, 3, "R7");
        acc(32'h2000_0004, 1'b0, 1'b1, 0, "R4");
        acc(32'h2000_1000, 1'b0, 1'b0, 0, "R2");
        wcfg(IX_FC, 32'h0);

        // R2: disabled region no longer matches
        wcfg(8, 32'h8);
        acc(32'h1000_0010, 1'b0, 1'b0, 2, "R2");
        acc(32'h1000_0010, 1'b1, 1'b0, 0, "R2");

        // R12: clear coinciding with a new fault
        tag = "R12";
        cfg_we = 1'b1; cfg_addr = 4'(IX_FC); cfg_wdata = '0;
        acc_valid = 1'b1; acc_addr = 32'h2000_0008; acc_write = 1'b1; acc_super = 1'b0;
        tick();
        cfg_we = 1'b0; acc_valid = 1'b0;
        check("R12 clear+fault cause", {30'b0, flt_cause}, 1);
        check("R12 clear+fault addr", flt_addr, 32'h2000_0008);
        tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule